// File: doc/BRIEF.md
# Oldest-First Issue Selector

This block picks one instruction per cycle from an out-of-order issue window for a single functional unit. Each window position presents a ready/request bit. Positions are kept compacted toward index 0 after every issue, and new instructions join at the high end. Index 0 is therefore always the oldest entry, and the selector gives it the highest priority.

Selection is built as a tree of four-input arbiter cells rather than as one flat priority encoder. In the first phase, every cell ORs its four child requests and passes the result to its parent. In the second phase, the root is enabled when the functional unit is free. Each enabled cell then forwards its enable to its lowest-indexed requesting child, until exactly one leaf holds the grant.

The window size is a parameter and must be a power of four. The default of 64 entries gives three levels of cells. The grant and its valid flag are registered, so they appear one clock after the request vector is sampled.

Top module: `issue_select`

## Requirements
- R1: While the active-low reset `rst_n` is asserted, `gnt_o` is all zeros and `valid_o` is low.
- R2: `gnt_o` and `valid_o` reflect the `req_i` and `unit_avail_i` values sampled at the previous rising clock edge and stay stable between edges.
- R3: At most one bit of `gnt_o` is set in any cycle.
- R4: When the unit is available and requests exist, the grant goes to the requesting entry with the lowest index. Bit 0 is the oldest entry and has top priority.
- R5: When no request bit is set, the next `gnt_o` is all zeros and `valid_o` is low.
- R6: When `unit_avail_i` is low, the next `gnt_o` is all zeros and `valid_o` is low, whatever the requests are.
- R7: `valid_o` is high exactly when `gnt_o` has a bit set.
- R8: A grant bit is set only for an entry whose request bit was set in the sampled vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | WINDOW | Ready/request bit per window entry; bit 0 is the oldest |
| unit_avail_i | input | 1 | The functional unit can accept an instruction this cycle |
| gnt_o | output | WINDOW | Registered one-hot (or zero) grant vector |
| valid_o | output | 1 | Registered flag: a grant was issued |

## Verification
Two conditions can fall in the same cycle: priority resolution among several competing entries, and the gate that blocks the root when the unit is unavailable. The bench provokes the overlap by driving request patterns with many bits set while `unit_avail_i` is low. In those cycles it expects an all-zero grant, not the lowest set bit. The grant is judged against the lowest set bit, computed in the bench as `req & -req`, over every request pattern of a 16-entry window. A separate pass re-checks a spread of those patterns with the unit unavailable.

// File: rtl/sel_pkg.sv
package sel_pkg;

    // Levels of radix-4 cells needed for a window of n entries (n = 4**levels).
    function automatic int tree_levels(input int n);
        int lv;
        int span;
        lv   = 0;
        span = 1;
        while (span < n) begin
            span = span * 4;
            lv   = lv + 1;
        end
        return lv;
    endfunction

    // Bit offset of tree level lvl inside the flattened node vector.
    // Level 0 holds the n leaves, level 1 holds n/4 nodes, and so on.
    function automatic int node_offset(input int n, input int lvl);
        int off;
        off = 0;
        for (int k = 0; k < lvl; k++) begin
            off = off + (n >> (2 * k));
        end
        return off;
    endfunction

    // Total node count over all levels, root included.
    function automatic int node_total(input int n);
        return node_offset(n, tree_levels(n) + 1);
    endfunction

endpackage

// File: rtl/sel_arb4.sv
module sel_arb4 (
    input  logic [3:0] req_i,
    input  logic       en_i,
    output logic       any_o,
    output logic [3:0] gnt_o
);

    // Request phase: tell the parent whether any child requests.
    // Grant phase: pass the enable to the lowest-indexed requesting child.
    always_comb begin
        any_o    = |req_i;
        gnt_o[0] = en_i & req_i[0];
        gnt_o[1] = en_i & req_i[1] & ~req_i[0];
        gnt_o[2] = en_i & req_i[2] & ~req_i[1] & ~req_i[0];
        gnt_o[3] = en_i & req_i[3] & ~req_i[2] & ~req_i[1] & ~req_i[0];
    end

endmodule

// File: rtl/sel_tree.sv
module sel_tree #(
    parameter int WINDOW = 64
) (
    input  logic [WINDOW-1:0] req_i,
    input  logic              root_en_i,
    output logic              any_o,
    output logic [WINDOW-1:0] gnt_o
);

    localparam int LEVELS = sel_pkg::tree_levels(WINDOW);
    localparam int TOTAL  = sel_pkg::node_total(WINDOW);

    // Flattened node vectors: leaves first, root in the top bit.
    logic [TOTAL-1:0] up_req;
    logic [TOTAL-1:0] down_gnt;

    assign up_req[WINDOW-1:0] = req_i;
    assign down_gnt[TOTAL-1]  = root_en_i;
    assign any_o              = up_req[TOTAL-1];
    assign gnt_o              = down_gnt[WINDOW-1:0];

    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_level
        localparam int CHILD_OFF = sel_pkg::node_offset(WINDOW, lv - 1);
        localparam int SELF_OFF  = sel_pkg::node_offset(WINDOW, lv);
        localparam int NODES     = WINDOW >> (2 * lv);
        for (genvar nd = 0; nd < NODES; nd++) begin : g_node
            sel_arb4 u_cell (
                .req_i (up_req[CHILD_OFF + 4*nd +: 4]),
                .en_i  (down_gnt[SELF_OFF + nd]),
                .any_o (up_req[SELF_OFF + nd]),
                .gnt_o (down_gnt[CHILD_OFF + 4*nd +: 4])
            );
        end
    end

endmodule

// File: rtl/issue_select.sv
module issue_select #(
    parameter int WINDOW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WINDOW-1:0] req_i,
    input  logic              unit_avail_i,
    output logic [WINDOW-1:0] gnt_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [WINDOW-1:0] gnt;
        logic              vld;
    } sel_state_t;

    sel_state_t state_d, state_q;

    logic              tree_any;
    logic [WINDOW-1:0] tree_gnt;

    sel_tree #(.WINDOW(WINDOW)) u_tree (
        .req_i     (req_i),
        .root_en_i (unit_avail_i),
        .any_o     (tree_any),
        .gnt_o     (tree_gnt)
    );

    always_comb begin
        state_d     = state_q;
        state_d.gnt = tree_gnt;
        state_d.vld = tree_any & unit_avail_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign gnt_o   = state_q.gnt;
    assign valid_o = state_q.vld;

endmodule

// File: rtl/issue_select_chk.sv
module issue_select_chk #(
    parameter int WINDOW = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WINDOW-1:0] req_i,
    input logic              unit_avail_i,
    input logic [WINDOW-1:0] gnt_o,
    input logic              valid_o
);

    localparam logic [WINDOW-1:0] ONE = {{(WINDOW-1){1'b0}}, 1'b1};

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (gnt_o == '0 && !valid_o));

    assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_oldest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> (($past(req_i) & (gnt_o - ONE)) == '0));

    assert_idle_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (gnt_o == '0 && !valid_o));

    assert_unit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_avail_i |=> (gnt_o == '0 && !valid_o));

    assert_valid_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (gnt_o != '0));

    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> ((gnt_o & ~$past(req_i)) == '0));

endmodule

bind issue_select issue_select_chk #(.WINDOW(WINDOW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .unit_avail_i (unit_avail_i),
    .gnt_o        (gnt_o),
    .valid_o      (valid_o)
);

// File: tb/issue_select_bench.sv
module issue_select_bench;

    localparam int W = 16;
    localparam int WATCHDOG_CYCLES = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] req_i = '0;
    logic         unit_avail_i = 1'b0;
    logic [W-1:0] gnt_o;
    logic         valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    issue_select #(.WINDOW(W)) u_issue_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .unit_avail_i (unit_avail_i),
        .gnt_o        (gnt_o),
        .valid_o      (valid_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one pattern, let one edge register it, then judge the outputs.
    task automatic apply(input logic [W-1:0] req, input logic av);
        logic [W-1:0] exp_g;
        logic         exp_v;
        @(negedge clk);
        req_i        = req;
        unit_avail_i = av;
        @(negedge clk);
        exp_g = av ? (req & (~req + 1'b1)) : '0;   // lowest set bit
        exp_v = av && (req != '0);
        check("R3", W'($countones(gnt_o) <= 1), W'(1));
        if (!av)
            check("R6", gnt_o, exp_g);
        else if (req == '0)
            check("R5", gnt_o, exp_g);
        else
            check("R4", gnt_o, exp_g);
        check("R8", gnt_o & ~req, '0);
        check("R7", W'(valid_o), W'(exp_v));
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: requests present during reset must not produce a grant.
        req_i        = 16'hffff;
        unit_avail_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", gnt_o, '0);
        check("R1", W'(valid_o), '0);
        rst_n = 1'b1;

        // R2: result appears one edge later and holds until the next edge.
        apply(16'h0008, 1'b1);
        req_i = 16'h0001;
        #5;
        check("R2", gnt_o, 16'h0008);
        @(negedge clk);
        check("R2", gnt_o, 16'h0001);

        // R4/R5/R7/R8: every 16-entry request pattern with the unit free.
        for (int p = 0; p < (1 << W); p++) begin
            apply(W'(p), 1'b1);
        end

        // R6: unit busy while many entries compete.
        for (int p = 1; p < (1 << W); p += 257) begin
            apply(W'(p), 1'b0);
        end
        apply(16'hffff, 1'b0);
        apply(16'h8000, 1'b1);
        apply(16'h8000, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule